// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master that lets software reach the registers of external Ethernet PHYs. It uses the extended-addressing (clause 45) frame format. Software packs a complete 32-bit frame image into a command word, then raises a trigger bit in a control word. The block divides the system clock down to the management clock (MDC). It sends a run of ones as preamble, followed by the frame, most significant bit first. For read frames it releases the data line for the turnaround and for the data bits, and collects 16 bits from the PHY.

One register access takes two frames: an address frame that names the target register, then a write or read frame with the same port and device address. Software sequences the two frames itself, polling a busy flag between them. When a read frame ends, the collected data replaces the low half of the command word, and software reads the result from there.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status word reads 0, the command and control words read 0, MDC is low and the MDIO output enable is low.
- R2: A write to control index 0x10 whose data has bit 3 set and bits 2:0 equal to 3'b101, while the stored control bit 3 is 0, starts a frame. Status bit 0 (index 0x14) reads 1 for exactly (PREAMBLE_LEN+32)*CLK_DIV clock cycles after the write edge, then reads 0.
- R3: A control write whose bits 2:0 differ from 3'b101, or a write of bit 3 while the stored bit 3 is already 1, starts no frame: status stays 0 and MDC stays low.
- R4: Each frame consists of PREAMBLE_LEN driven ones followed by the 32 command bits, bit 31 first. Every bit is driven for address (op 2'b00, bits 29:28) and write (op 2'b01) frames. MDIO changes only in the clock cycle where MDC falls.
- R5: While a frame is in flight, MDC has a period of CLK_DIV system clocks, giving PREAMBLE_LEN+32 rising edges per frame. MDC never rises while idle.
- R6: For a read frame (op 2'b11), MDIO is driven for the first 14 frame bits and released for frame bits 14 to 31. The bits sampled on the last 16 MDC rising edges, first sample as bit 15, replace command bits 15:0, and bits 31:16 keep their values.
- R7: A start request while busy is ignored, including one that arrives in the very cycle the frame completes. Busy then reads 0 in the following cycle.
- R8: A write to the command word (index 0x11) while busy is ignored.
- R9: Control and command words read back what was written. The status word reads busy in bit 0 and zeros elsewhere. Any other index reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Two events can fall on the same clock edge: the last MDC falling edge of a frame, which clears busy and writes read data back, and a fresh start request from software. The bench counts clock cycles from the start edge and places a second trigger write exactly on the completion edge, after an earlier trigger was already rejected in the middle of the frame. It then checks that busy reads 1 one cycle before that edge and 0 after it, that MDC stays low, and that no extra frame appears on the wire. Within the same frame, a command write made mid-frame must leave the upper command bits intact once the captured data has landed.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    localparam int unsigned FRAME_BITS = 32;

    // control word: trigger bit and required enable pattern
    localparam int unsigned TRIG_BIT   = 3;
    localparam logic [2:0]  ARM_CODE   = 3'b101;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RINC  = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]  st;
        mdio_op_e    op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [1:0]  ta;
        logic [15:0] payload;
    } mdio_frame_t;

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
    parameter int unsigned CLK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_end;

    assign at_end = run && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (at_end) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = at_end && !st_q.mdc;
    assign fall_tick = at_end &&  st_q.mdc;

endmodule

// File: rtl/mdio_c45_shifter.sv
module mdio_c45_shifter
    import mdio_c45_pkg::*;
#(
    parameter int unsigned PREAMBLE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_frame_t frame_in,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        frame_end,
    output logic [15:0] rd_data
);
    localparam int unsigned TOTAL = PREAMBLE_LEN + FRAME_BITS;
    localparam int unsigned IW    = $clog2(TOTAL + 1);
    localparam logic [IW-1:0] PRE_W  = IW'(PREAMBLE_LEN);
    localparam logic [IW-1:0] LAST_W = IW'(TOTAL - 1);
    localparam logic [IW-1:0] DATA_W = IW'(PREAMBLE_LEN + 16);
    localparam logic [IW-1:0] REL_P  = IW'(14);

    typedef struct packed {
        logic        busy;
        logic [IW-1:0] idx;
        mdio_frame_t frame;
        logic        is_read;
        logic [15:0] cap;
        logic        mdo;
        logic        oe;
    } shf_state_t;

    shf_state_t st_d, st_q;

    // returns {oe, value} for a bit position of the frame
    function automatic logic [1:0] drive_at(logic [IW-1:0] idx, mdio_frame_t fr, logic rd);
        logic [IW-1:0] p;
        logic [4:0]    bp;
        logic [31:0]   w;
        w  = fr;
        p  = idx - PRE_W;
        bp = 5'd31 - p[4:0];
        if (idx < PRE_W)        return 2'b11;
        if (rd && (p >= REL_P)) return 2'b00;
        return {1'b1, w[bp]};
    endfunction

    always_comb begin
        logic [1:0] drv;
        st_d      = st_q;
        frame_end = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.idx     = '0;
                st_d.frame   = frame_in;
                st_d.is_read = (frame_in.op == OP_READ);
                st_d.cap     = '0;
            end
        end else begin
            if (rise_tick && st_q.is_read && (st_q.idx >= DATA_W)) begin
                st_d.cap = {st_q.cap[14:0], mdio_i};
            end
            if (fall_tick) begin
                if (st_q.idx == LAST_W) begin
                    st_d.busy = 1'b0;
                    frame_end = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
        if (st_d.busy) drv = drive_at(st_d.idx, st_d.frame, st_d.is_read);
        else           drv = 2'b00;
        st_d.oe  = drv[1];
        st_d.mdo = drv[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign mdio_o  = st_q.mdo;
    assign mdio_oe = st_q.oe;
    assign rd_data = st_q.cap;

endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
    import mdio_c45_pkg::*;
#(
    parameter int unsigned AW       = 5,
    parameter int unsigned IDX_CTRL = 'h10,
    parameter int unsigned IDX_CMD  = 'h11,
    parameter int unsigned IDX_STAT = 'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy,
    input  logic          frame_end,
    input  logic [15:0]   rd_data,
    output logic          start_req,
    output mdio_frame_t   cmd
);
    localparam logic [AW-1:0] A_CTRL = AW'(IDX_CTRL);
    localparam logic [AW-1:0] A_CMD  = AW'(IDX_CMD);
    localparam logic [AW-1:0] A_STAT = AW'(IDX_STAT);

    typedef struct packed {
        mdio_frame_t cmd;
        logic [31:0] ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       wr_ctrl, wr_cmd;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_cmd  = reg_wr && (reg_addr == A_CMD);

    // trigger: bit goes 0 -> 1 with the arm pattern present
    assign start_req = wr_ctrl && reg_wdata[TRIG_BIT] && !st_q.ctrl[TRIG_BIT]
                       && (reg_wdata[2:0] == ARM_CODE);

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = reg_wdata;
        if (wr_cmd && !busy) st_d.cmd = mdio_frame_t'(reg_wdata);
        if (frame_end && (st_q.cmd.op == OP_READ)) st_d.cmd.payload = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = st_q.ctrl;
            A_CMD:   reg_rdata = st_q.cmd;
            A_STAT:  reg_rdata = {31'd0, busy};
            default: reg_rdata = '0;
        endcase
    end

    assign cmd = st_q.cmd;

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int unsigned CLK_DIV      = 50,
    parameter int unsigned PREAMBLE_LEN = 32,
    parameter int unsigned AW           = 5,
    parameter int unsigned IDX_CTRL     = 'h10,
    parameter int unsigned IDX_CMD      = 'h11,
    parameter int unsigned IDX_STAT     = 'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    logic        busy_w;
    logic        start_w;
    logic        frame_end_w;
    logic        rise_w, fall_w;
    logic [15:0] cap_w;
    mdio_frame_t cmd_w;

    mdio_c45_regs #(
        .AW(AW), .IDX_CTRL(IDX_CTRL), .IDX_CMD(IDX_CMD), .IDX_STAT(IDX_STAT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .frame_end (frame_end_w),
        .rd_data   (cap_w),
        .start_req (start_w),
        .cmd       (cmd_w)
    );

    mdio_c45_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_c45_shifter #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .frame_in  (cmd_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .busy      (busy_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .frame_end (frame_end_w),
        .rd_data   (cap_w)
    );

endmodule

// File: rtl/mdio_c45_master_checker.sv
module mdio_c45_master_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        frame_end,
    input logic [31:0] cmd_word
);
    AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R1

    AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R4

    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R5

    AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !busy); // R7

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_word)); // R8
endmodule

bind mdio_c45_master mdio_c45_master_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end_w),
    .cmd_word  (cmd_w)
);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;
    localparam int DIV   = 8;
    localparam int PRE   = 32;
    localparam int TOTAL = PRE + 32;
    localparam int N     = TOTAL * DIV;
    localparam logic [4:0] A_CTRL = 5'h10;
    localparam logic [4:0] A_CMD  = 5'h11;
    localparam logic [4:0] A_STAT = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        drv_bit = 1'b1;

    always #4 clk = ~clk;

    mdio_c45_master #(.CLK_DIV(DIV), .PREAMBLE_LEN(PRE)) u_mdio_c45_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(drv_bit)
    );

    int n_chk = 0;
    int n_bad = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    int rc = 0;
    logic [15:0] phy_word = '0;
    logic [31:0] exp_q[$];
    logic [TOTAL-1:0] seen_o, seen_oe;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'd1;
        for (int k = 0; k < 4 * N; k++) begin
            rd(A_STAT, s);
            if (s[0] == 1'b0) break;
        end
        check(s[0] == 1'b0, "R2 busy clears after frame", s, 32'd0);
    endtask

    // driver: queue the expected frame, then trigger it
    task automatic run_frame(input logic [31:0] word, input logic [15:0] phy);
        exp_q.push_back(word);
        frames_sent++;
        phy_word = phy;
        wr(A_CMD, word);
        wr(A_CTRL, 32'h5);
        wr(A_CTRL, 32'hD);
        wr(A_CTRL, 32'h5);
        wait_idle();
        check(frames_seen == frames_sent, "R5 rising MDC edges per frame", frames_seen, frames_sent);
    endtask

    // PHY model: presents the next bit after each MDC fall
    always @(negedge mdc) begin
        if (rc >= PRE + 16) drv_bit = phy_word[15 - (rc - PRE - 16)];
        else                drv_bit = 1'b1;
    end

    // monitor: record every MDC rise, compare a full frame against the queue
    always @(posedge mdc) begin
        seen_o[rc]  = mdio_o;
        seen_oe[rc] = mdio_oe;
        rc++;
        if (rc == TOTAL) begin
            logic [31:0] w;
            logic [TOTAL-1:0] e_o, e_oe;
            bit is_rd;
            rc = 0;
            frames_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected frame on the wire", 32'd1, 32'd0);
            end else begin
                w = exp_q.pop_front();
                is_rd = (w[29:28] == 2'b11);
                for (int i = 0; i < TOTAL; i++) begin
                    if (i < PRE) begin
                        e_o[i] = 1'b1; e_oe[i] = 1'b1;
                    end else if (is_rd && (i - PRE) >= 14) begin
                        e_o[i] = 1'b0; e_oe[i] = 1'b0;
                    end else begin
                        e_o[i] = w[31 - (i - PRE)]; e_oe[i] = 1'b1;
                    end
                end
                check((seen_oe == e_oe) && ((seen_o & e_oe) == (e_o & e_oe)),
                      is_rd ? "R6 read frame drive and release" : "R4 preamble and frame bits",
                      seen_o[TOTAL-1:TOTAL-32] & e_oe[TOTAL-1:TOTAL-32], e_o[TOTAL-1:TOTAL-32]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] word;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, v); check(v == 32'd0, "R1 status after reset", v, 32'd0);
        rd(A_CMD, v);  check(v == 32'd0, "R1 command after reset", v, 32'd0);
        rd(A_CTRL, v); check(v == 32'd0, "R1 control after reset", v, 32'd0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line idle after reset", {mdc, mdio_oe}, 32'd0);

        // R9 register map
        wr(A_CMD, 32'h1234_5678);
        rd(A_CMD, v);  check(v == 32'h1234_5678, "R9 command readback", v, 32'h1234_5678);
        wr(A_CTRL, 32'h0000_0004);
        rd(A_CTRL, v); check(v == 32'h4, "R9 control readback", v, 32'h4);
        rd(5'h03, v);  check(v == 32'd0, "R9 unmapped index reads zero", v, 32'd0);

        // R3 wrong arm pattern, then no rising edge
        wr(A_CTRL, 32'hC);
        repeat (3 * DIV) @(negedge clk);
        rd(A_STAT, v); check(v[0] == 1'b0 && mdc == 1'b0, "R3 bad arm pattern ignored", v, 32'd0);
        wr(A_CTRL, 32'hD);
        repeat (3 * DIV) @(negedge clk);
        rd(A_STAT, v); check(v[0] == 1'b0 && mdc == 1'b0, "R3 trigger already high ignored", v, 32'd0);
        wr(A_CTRL, 32'h5);

        // R4 address and write frames, R6 reads with several data patterns
        run_frame({2'b00, 2'b00, 5'd3, 5'd5, 2'b10, 16'hBEEF}, 16'h0000);
        run_frame({2'b00, 2'b01, 5'd3, 5'd5, 2'b10, 16'h5A0F}, 16'h0000);
        run_frame({2'b00, 2'b00, 5'd31, 5'd1, 2'b10, 16'h0000}, 16'h0000);
        run_frame({2'b00, 2'b11, 5'd31, 5'd1, 2'b10, 16'h0000}, 16'hA5C3);
        rd(A_CMD, v); check(v == {2'b00, 2'b11, 5'd31, 5'd1, 2'b10, 16'hA5C3}, "R6 read data written back", v, {2'b00, 2'b11, 5'd31, 5'd1, 2'b10, 16'hA5C3});
        run_frame({2'b00, 2'b11, 5'd1, 5'd30, 2'b10, 16'hFFFF}, 16'h0001);
        rd(A_CMD, v); check(v == {2'b00, 2'b11, 5'd1, 5'd30, 2'b10, 16'h0001}, "R6 LSB only", v, {2'b00, 2'b11, 5'd1, 5'd30, 2'b10, 16'h0001});
        run_frame({2'b00, 2'b11, 5'd16, 5'd7, 2'b10, 16'h1234}, 16'h8000);
        rd(A_CMD, v); check(v == {2'b00, 2'b11, 5'd16, 5'd7, 2'b10, 16'h8000}, "R6 MSB only", v, {2'b00, 2'b11, 5'd16, 5'd7, 2'b10, 16'h8000});

        // R2 exact duration, R7 retrigger mid-frame and on the completion edge, R8 frozen command
        word = {2'b00, 2'b11, 5'd9, 5'd5, 2'b10, 16'h0000};
        exp_q.push_back(word);
        frames_sent++;
        phy_word = 16'h3C96;
        wr(A_CMD, word);
        wr(A_CTRL, 32'h5);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'hD;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        for (int j = 1; j <= N; j++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            reg_addr = A_STAT;
            #1;
            if (j == N - 1) check(reg_rdata[0] == 1'b1, "R2 busy in last frame cycle", reg_rdata, 32'd1);
            if (j == N)     check(reg_rdata[0] == 1'b0, "R7 start on completion edge ignored", reg_rdata, 32'd0);
            if (j == 20)    begin reg_wr = 1'b1; reg_addr = A_CMD;  reg_wdata = 32'hFFFF_FFFF; end
            if (j == 40)    begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h5; end
            if (j == 60)    begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'hD; end
            if (j == 61)    begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h5; end
            if (j == N - 1) begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'hD; end
        end
        repeat (3 * DIV) @(negedge clk);
        rd(A_STAT, v); check(v[0] == 1'b0 && mdc == 1'b0, "R7 no second frame started", v, 32'd0);
        check(frames_seen == frames_sent, "R7 one frame on the wire", frames_seen, frames_sent);
        rd(A_CMD, v); check(v == {word[31:16], 16'h3C96}, "R8 command write while busy dropped", v, {word[31:16], 16'h3C96});

        finish_run();
    end
endmodule